// File: doc/BRIEF.md
# Per-Channel Gain and Offset Trim Engine for a Multichannel DAC

This block is the digital core that sits between a host write port and a bank of 14-bit voltage DAC channels. The host presents a channel number, a 2-bit target select and a 14-bit word. Depending on the select code, the word lands in that channel's raw input code, its signed offset trim or its gain trim. Every accepted write starts a recomputation of that channel's trimmed code. A single shared arithmetic path does the work, so only the channel that was written is recomputed. The result is held in a pending register for that channel.

A load strobe copies the pending codes of all channels into the output registers on one clock edge, so the analog outputs can be moved together. The trimmed code is the input code scaled by (gain + 2)/16384, truncated, then shifted by the offset minus 8192. The result is clamped to the 14-bit range. With its reset coefficients each channel passes its input code through unchanged.

Top module: `dac_trim_engine`

## Requirements
- R1: After reset every output code is 0, each channel's gain trim holds 0x3FFE and its offset trim holds 0x2000. A channel whose trims were never written therefore outputs its input code unchanged after a load.
- R2: A write with select 2'b11 targets the input code, 2'b10 targets the offset trim and 2'b01 targets the gain trim.
- R3: The trimmed code is floor(((gain + 2) × input) / 16384) + (offset − 8192), computed at full product precision.
- R4: Bit 0 of a written gain word is discarded, so the gain trim always has bit 0 clear. For example, a written 0x0FFF acts as 0x0FFE.
- R5: A trimmed result above 16383 is clamped to 16383.
- R6: A trimmed result below 0 is clamped to 0.
- R7: An output code changes only on a clock edge at which the load strobe is high. On such an edge all channels take their pending codes together.
- R8: The pending code of a written channel is updated two clock edges after the edge that accepts the write. A load sampled at the write edge or at the two edges after it outputs the previous pending code. A load sampled at the third edge or later outputs the new code.
- R9: A write with select 2'b00 changes no trim, input code or output.
- R10: A write to a channel number of 40 or above changes no channel.
- R11: A write to one channel leaves the codes of all other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, sampled on the rising edge |
| wr_ch | input | 6 | Target channel number |
| wr_sel | input | 2 | Target select: 11 input code, 10 offset, 01 gain, 00 ignored |
| wr_data | input | 14 | Write word |
| load | input | 1 | Copy all pending codes to the outputs |
| dac_codes | output | 560 | Output codes, channel k in bits [14k+13:14k] |

## Verification
The two functions that can fall in the same cycle are the recomputation of a channel's pending code and the global load that copies pending codes to the outputs. The bench provokes this collision by writing a fresh input code with the load strobe already high, then keeps the strobe high on each following edge. After every edge it compares the written channel's output with the value R8 predicts: the previous code for the first three edges and the new code from the fourth. The checker also requires that any load edge yields exactly the pending codes of the cycle before it.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   typedef enum logic [1:0] {
      SEL_SFR  = 2'b00,
      SEL_GAIN = 2'b01,
      SEL_OFFS = 2'b10,
      SEL_DATA = 2'b11
   } sel_e;

   function automatic logic sel_is_trim_target(input logic [1:0] sel);
      return (sel != SEL_SFR);
   endfunction

endpackage

// File: rtl/dacfe_regbank.sv
module dacfe_regbank
   import dacfe_pkg::*;
#(
   parameter int NCH = 40,
   parameter int DW  = 14,
   parameter int CHW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [CHW-1:0] wr_ch,
   input  logic [1:0]     wr_sel,
   input  logic [DW-1:0]  wr_data,
   output logic           upd_vld,
   output logic [CHW-1:0] upd_ch,
   output logic [DW-1:0]  rd_x1,
   output logic [DW-1:0]  rd_c,
   output logic [DW-1:0]  rd_m
);
   localparam logic [DW-1:0] GAIN_RST = DW'((1 << DW) - 2);
   localparam logic [DW-1:0] OFFS_RST = DW'(1 << (DW - 1));
   localparam logic [CHW:0]  NCH_L    = (CHW + 1)'(NCH);

   logic           accept;
   logic [DW-1:0]  x1_arr [NCH];
   logic [DW-1:0]  c_arr  [NCH];
   logic [DW-1:0]  m_arr  [NCH];

   always_comb begin
      accept = wr_en && sel_is_trim_target(wr_sel) && ({1'b0, wr_ch} < NCH_L);
   end

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic          hit;
      logic [DW-1:0] x1_q;
      logic [DW-1:0] c_q;
      logic [DW-1:1] mh_q;

      assign hit = accept && (wr_ch == CHW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            x1_q <= '0;
            c_q  <= OFFS_RST;
            mh_q <= GAIN_RST[DW-1:1];
         end else if (hit) begin
            case (sel_e'(wr_sel))
               SEL_DATA: x1_q <= wr_data;
               SEL_OFFS: c_q  <= wr_data;
               SEL_GAIN: mh_q <= wr_data[DW-1:1];
               default:  ;
            endcase
         end
      end

      assign x1_arr[g] = x1_q;
      assign c_arr[g]  = c_q;
      assign m_arr[g]  = {mh_q, 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_vld <= 1'b0;
         upd_ch  <= '0;
      end else begin
         upd_vld <= accept;
         upd_ch  <= wr_ch;
      end
   end

   always_comb begin
      rd_x1 = x1_arr[upd_ch];
      rd_c  = c_arr[upd_ch];
      rd_m  = m_arr[upd_ch];
   end

endmodule

// File: rtl/dacfe_corrector.sv
module dacfe_corrector #(
   parameter int DW        = 14,
   parameter int CHW       = 6,
   parameter int PIPE_MULT = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic [CHW-1:0] in_ch,
   input  logic [DW-1:0]  in_x1,
   input  logic [DW-1:0]  in_c,
   input  logic [DW-1:0]  in_m,
   output logic           out_vld,
   output logic [CHW-1:0] out_ch,
   output logic [DW-1:0]  out_code
);
   localparam int GW = DW + 1;
   localparam int PW = GW + DW;
   localparam int SW = DW + 3;
   localparam logic signed [SW-1:0] BIAS = SW'(1 << (DW - 1));
   localparam logic signed [SW-1:0] MAXS = SW'((1 << DW) - 1);

   logic [GW-1:0]  gain;
   logic [PW-1:0]  prod;
   logic [GW-1:0]  scaled;

   always_comb begin
      gain   = {1'b0, in_m} + GW'(2);
      prod   = PW'(gain) * PW'(in_x1);
      scaled = prod[PW-1:DW];
   end

   logic           s_vld;
   logic [CHW-1:0] s_ch;
   logic [GW-1:0]  s_scaled;
   logic [DW-1:0]  s_c;

   if (PIPE_MULT != 0) begin : g_piped
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_vld    <= 1'b0;
            s_ch     <= '0;
            s_scaled <= '0;
            s_c      <= '0;
         end else begin
            s_vld    <= in_vld;
            s_ch     <= in_ch;
            s_scaled <= scaled;
            s_c      <= in_c;
         end
      end
   end else begin : g_flat
      assign s_vld    = in_vld;
      assign s_ch     = in_ch;
      assign s_scaled = scaled;
      assign s_c      = in_c;
   end

   logic signed [SW-1:0] offs;
   logic signed [SW-1:0] sum;

   always_comb begin
      offs = $signed({3'b000, s_c}) - BIAS;
      sum  = $signed({2'b00, s_scaled}) + offs;
      if (sum[SW-1])
         out_code = '0;
      else if (sum > MAXS)
         out_code = '1;
      else
         out_code = sum[DW-1:0];
      out_vld = s_vld;
      out_ch  = s_ch;
   end

endmodule

// File: rtl/dacfe_dacbank.sv
module dacfe_dacbank #(
   parameter int NCH = 40,
   parameter int DW  = 14,
   parameter int CHW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pw_vld,
   input  logic [CHW-1:0]    pw_ch,
   input  logic [DW-1:0]     pw_code,
   input  logic              load,
   output logic [NCH*DW-1:0] pend_flat,
   output logic [NCH*DW-1:0] dac_flat
);
   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic          we;
      logic [DW-1:0] pend_q;
      logic [DW-1:0] dac_q;

      assign we = pw_vld && (pw_ch == CHW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= '0;
            dac_q  <= '0;
         end else begin
            if (we)
               pend_q <= pw_code;
            if (load)
               dac_q <= pend_q;
         end
      end

      assign pend_flat[g*DW +: DW] = pend_q;
      assign dac_flat[g*DW +: DW]  = dac_q;
   end

endmodule

// File: rtl/dac_trim_engine.sv
module dac_trim_engine #(
   parameter int NCH       = 40,
   parameter int DW        = 14,
   parameter int CHW       = 6,
   parameter int PIPE_MULT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHW-1:0]    wr_ch,
   input  logic [1:0]        wr_sel,
   input  logic [DW-1:0]     wr_data,
   input  logic              load,
   output logic [NCH*DW-1:0] dac_codes
);
   if (NCH < 1 || NCH > (1 << CHW)) begin : g_bad_nch
      $error("dac_trim_engine: NCH must lie in 1..2**CHW");
   end
   if (DW < 4) begin : g_bad_dw
      $error("dac_trim_engine: DW must be at least 4");
   end
   if (PIPE_MULT < 0 || PIPE_MULT > 1) begin : g_bad_pipe
      $error("dac_trim_engine: PIPE_MULT must be 0 or 1");
   end

   logic              rb_vld;
   logic [CHW-1:0]    rb_ch;
   logic [DW-1:0]     rb_x1;
   logic [DW-1:0]     rb_c;
   logic [DW-1:0]     rb_m;
   logic              crr_vld;
   logic [CHW-1:0]    crr_ch;
   logic [DW-1:0]     crr_code;
   logic [NCH*DW-1:0] pend_flat;

   dacfe_regbank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_regbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ch   (wr_ch),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .upd_vld (rb_vld),
      .upd_ch  (rb_ch),
      .rd_x1   (rb_x1),
      .rd_c    (rb_c),
      .rd_m    (rb_m)
   );

   dacfe_corrector #(.DW(DW), .CHW(CHW), .PIPE_MULT(PIPE_MULT)) u_corrector (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (rb_vld),
      .in_ch    (rb_ch),
      .in_x1    (rb_x1),
      .in_c     (rb_c),
      .in_m     (rb_m),
      .out_vld  (crr_vld),
      .out_ch   (crr_ch),
      .out_code (crr_code)
   );

   dacfe_dacbank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_dacbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pw_vld    (crr_vld),
      .pw_ch     (crr_ch),
      .pw_code   (crr_code),
      .load      (load),
      .pend_flat (pend_flat),
      .dac_flat  (dac_codes)
   );

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
   parameter int NCH       = 40,
   parameter int DW        = 14,
   parameter int PIPE_MULT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic [NCH*DW-1:0] dac_codes,
   input logic [NCH*DW-1:0] pend_flat,
   input logic              rb_vld,
   input logic [DW-1:0]     rb_x1,
   input logic [DW-1:0]     rb_c,
   input logic [DW-1:0]     rb_m,
   input logic              crr_vld,
   input logic [DW-1:0]     crr_code
);
   localparam logic [DW-1:0] GAIN_ONE = DW'((1 << DW) - 2);
   localparam logic [DW-1:0] OFFS_ZERO = DW'(1 << (DW - 1));

   // R7
   hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(dac_codes));

   // R7
   load_takes_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (dac_codes == $past(pend_flat)));

   if (PIPE_MULT != 0) begin : g_p1
      // R1
      unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rb_vld && rb_m == GAIN_ONE && rb_c == OFFS_ZERO)
         |=> (crr_vld && crr_code == $past(rb_x1)));
      // R5
      clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rb_vld && rb_m == GAIN_ONE && rb_c == '1 && rb_x1[DW-1])
         |=> (crr_vld && crr_code == '1));
      // R6
      clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rb_vld && rb_m == GAIN_ONE && rb_c == '0 && !rb_x1[DW-1])
         |=> (crr_vld && crr_code == '0));
   end else begin : g_p0
      // R1
      unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rb_vld && rb_m == GAIN_ONE && rb_c == OFFS_ZERO)
         |-> (crr_vld && crr_code == rb_x1));
      // R5
      clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rb_vld && rb_m == GAIN_ONE && rb_c == '1 && rb_x1[DW-1])
         |-> (crr_vld && crr_code == '1));
      // R6
      clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rb_vld && rb_m == GAIN_ONE && rb_c == '0 && !rb_x1[DW-1])
         |-> (crr_vld && crr_code == '0));
   end

endmodule

bind dac_trim_engine dacfe_chk #(.NCH(NCH), .DW(DW), .PIPE_MULT(PIPE_MULT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .dac_codes (dac_codes),
   .pend_flat (pend_flat),
   .rb_vld    (rb_vld),
   .rb_x1     (rb_x1),
   .rb_c      (rb_c),
   .rb_m      (rb_m),
   .crr_vld   (crr_vld),
   .crr_code  (crr_code)
);

// File: tb/test_dac_trim_engine.sv
module test_dac_trim_engine;
   localparam int NCH = 40;
   localparam int DW  = 14;
   localparam int CHW = 6;
   localparam int NV  = 8;

   // fields: ch[61:56] gain[55:42] offset[41:28] input[27:14] expected[13:0]
   localparam logic [61:0] VEC [NV] = '{
      {6'd5,  14'h1FFE, 14'h2000, 14'h3000, 14'h1800},
      {6'd39, 14'h3FFE, 14'h2010, 14'd100,  14'd116},
      {6'd12, 14'h3FFE, 14'h3FFF, 14'h3000, 14'h3FFF},
      {6'd20, 14'h3FFE, 14'h0000, 14'd100,  14'h0000},
      {6'd7,  14'h0FFF, 14'h2000, 14'h3FFF, 14'd4095},
      {6'd1,  14'h0000, 14'h2000, 14'h3FFF, 14'd1},
      {6'd2,  14'h3FFE, 14'h1FFF, 14'h0000, 14'h0000},
      {6'd3,  14'h2FFE, 14'h2005, 14'h2000, 14'd6149}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [CHW-1:0]    wr_ch = '0;
   logic [1:0]        wr_sel = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              load = 1'b0;
   logic [NCH*DW-1:0] dac_codes;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_dac [NCH];
   string vtag [NV] = '{"R2", "R3", "R5", "R6", "R4", "R3", "R6", "R2"};

   always #5 clk = ~clk;

   dac_trim_engine i_dac_trim_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_ch     (wr_ch),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .load      (load),
      .dac_codes (dac_codes)
   );

   task automatic chk(input string tag, input int ch, input logic [DW-1:0] exp);
      logic [DW-1:0] act;
      act = dac_codes[ch*DW +: DW];
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int k = 0; k < NCH; k++) chk(tag, k, exp_dac[k]);
   endtask

   task automatic wr(input int ch, input logic [1:0] sel, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = CHW'(ch); wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_load();
      @(negedge clk);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NCH; k++) exp_dac[k] = '0;
      idle(4);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state of all outputs
      chk_all("R1");

      // R1: default gain and offset pass the input code through
      wr(0, 2'b11, 14'h1234);
      idle(3);
      pulse_load();
      exp_dac[0] = 14'h1234;
      chk("R1", 0, exp_dac[0]);

      for (int v = 0; v < NV; v++) begin
         int ch;
         ch = int'(VEC[v][61:56]);
         wr(ch, 2'b01, VEC[v][55:42]);
         wr(ch, 2'b10, VEC[v][41:28]);
         wr(ch, 2'b11, VEC[v][27:14]);
         idle(3);
         // R7: nothing moves before the load
         chk("R7", ch, exp_dac[ch]);
         pulse_load();
         exp_dac[ch] = VEC[v][13:0];
         chk(vtag[v], ch, exp_dac[ch]);
         // R11: other channels untouched
         chk_all("R11");
      end

      // R9: select 00 must not alter channel 0
      wr(0, 2'b00, 14'h0000);
      idle(3);
      pulse_load();
      chk("R9", 0, exp_dac[0]);

      // R10: out-of-range channel numbers
      wr(40, 2'b11, 14'h0000);
      wr(63, 2'b10, 14'h0000);
      wr(41, 2'b01, 14'h0000);
      idle(3);
      pulse_load();
      chk_all("R10");

      // R8: write and load in the same cycle, load kept high
      @(negedge clk);
      wr_en = 1'b1; wr_ch = CHW'(4); wr_sel = 2'b11; wr_data = 14'h0777; load = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8", 4, 14'h0000);
      @(negedge clk);
      chk("R8", 4, 14'h0000);
      @(negedge clk);
      chk("R8", 4, 14'h0000);
      @(negedge clk);
      chk("R8", 4, 14'h0777);
      load = 1'b0;
      exp_dac[4] = 14'h0777;
      idle(2);
      // R7: outputs hold once the strobe drops
      chk_all("R7");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule